// File: doc/BRIEF.md
# Double-Buffered Serial Crossbar Route Loader

This block is the digital control front end for an eight-input, four-output analog crossbar. A host shifts routing data in over three serial pins: an active-low select, a serial clock and a data line. The bits land in a staging register. A separate commit strobe then copies the staged contents into the live routing register that drives the switch selects. Because shifting and committing are two separate steps, several crossbars on one board can be loaded one after another and then switched over together on a shared commit line.

A format pin picks between two frame layouts. In full-frame mode, sixteen bits rewrite all four routes. In per-output mode, a six-bit frame names one output and replaces only that output's staged route. A board can also tie commit to the select pin, so that ending a frame also applies it. All serial pins are sampled in the system clock domain, and their edges are detected there.

Top module: `xpt_route_loader`

## Requirements
- R1: A rising edge on `commit_i` copies the whole staging register into `route_o`, but only when a complete frame has been staged since the previous copy.
- R2: Shifting bits in, with no commit edge, never changes `route_o`.
- R3: A commit edge that comes with no complete frame staged since the last copy leaves `route_o` unchanged. This includes the case where only a partial frame was shifted in.
- R4: With `fmt_addr_i` = 0, sixteen captured bits form the frame. The first captured bit becomes `route_o[0]`. Output n is held in bits 4n+3..4n, where bits 2..0 are the input select and bit 3 is the enable.
- R5: With `fmt_addr_i` = 1, each six captured bits form one frame. The first two bits are the output address, least significant bit first. The next four bits are that output's route word, least significant bit first. Only that output's staged word changes. Several frames may follow one another in one select-low session.
- R6: A per-output frame cut short by `sel_n_i` rising is not marked as new. A commit after it has no effect, and the next session starts counting at the first bit again.
- R7: A bit is captured on a falling edge of `sclk_i` only after a rising edge of `sclk_i` has been seen in the same select-low session. A falling edge that comes before any rising edge is ignored.
- R8: In full-frame mode, clocking more than sixteen bits keeps shifting. After 16+k bits, the staged frame holds the last sixteen bits.
- R9: While `sel_n_i` is high, clock edges capture nothing, so a commit afterwards leaves `route_o` unchanged.
- R10: A commit works whether `sel_n_i` is low or high.
- R11: With `commit_i` wired to `sel_n_i`, raising the select at the end of a complete frame applies that frame.
- R12: After reset, `route_o` is all zero, which means every output is disabled, and nothing is staged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk` |
| sdata_i | input | 1 | Serial data |
| commit_i | input | 1 | Commit strobe; its rising edge applies staged data |
| fmt_addr_i | input | 1 | 0 = full-frame format, 1 = per-output format |
| route_o | output | 16 | Live routing, four 4-bit words {enable, select[2:0]} |

## Verification
The hardest state to reach from the ports is a select-low session whose first clock event is a falling edge. The stimulus gets there by parking the serial clock high before lowering the select, then driving a single falling edge with a data value that would visibly shift the frame if it were captured. Per-output frames are swept over every address and every route word. Truncated frames and back-to-back frames in one session then check the frame counter's restart behaviour.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int XPT_INPUTS  = 8;
  localparam int XPT_OUTPUTS = 4;
  localparam int XPT_SYNC    = 2;
endpackage

// File: rtl/xpt_in_sync.sv
module xpt_in_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST;
        else        chain[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xpt_load.sv
module xpt_load #(
  parameter int OUTS   = 4,
  parameter int WORD_W = 4,
  parameter int ADDR_W = 2,
  localparam int FRAME_W  = OUTS * WORD_W,
  localparam int AFRAME_W = ADDR_W + WORD_W,
  localparam int CNT_W    = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_active_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               sdata_i,
  input  logic               addr_mode_i,
  input  logic               commit_edge_i,
  output logic [FRAME_W-1:0] stage_o,
  output logic               pending_o
);
  logic                armed;
  logic [CNT_W-1:0]    cnt;
  logic [AFRAME_W-1:0] aframe;
  logic [AFRAME_W-1:0] afull;
  logic [ADDR_W-1:0]   a_addr;
  logic [WORD_W-1:0]   a_word;
  logic                take, a_last, s_last, frame_done;

  assign take   = cs_active_i && armed && sclk_fall_i;
  assign a_last = (cnt == CNT_W'(AFRAME_W - 1));
  assign s_last = (cnt >= CNT_W'(FRAME_W - 1));
  assign frame_done = take && (addr_mode_i ? a_last : s_last);
  assign afull  = {sdata_i, aframe[AFRAME_W-1:1]};
  assign a_addr = afull[ADDR_W-1:0];
  assign a_word = afull[AFRAME_W-1:ADDR_W];

  // Session state: arm on a rising clock, count captured bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!cs_active_i) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      if (sclk_rise_i) armed <= 1'b1;
      if (take) begin
        if (addr_mode_i) cnt <= a_last ? '0 : cnt + 1'b1;
        else if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aframe <= '0;
    else if (take && addr_mode_i) aframe <= afull;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_o <= '0;
    end else if (take && !addr_mode_i) begin
      stage_o <= {sdata_i, stage_o[FRAME_W-1:1]};
    end else if (frame_done && addr_mode_i) begin
      for (int o = 0; o < OUTS; o++)
        if (a_addr == ADDR_W'(o)) stage_o[o*WORD_W +: WORD_W] <= a_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pending_o <= 1'b0;
    else if (frame_done)    pending_o <= 1'b1;
    else if (commit_edge_i) pending_o <= 1'b0;
  end

  a_r9_deselect_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active_i |=> $stable(stage_o));
  a_r7_unarmed_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !sclk_rise_i) |=> !armed);
  a_r7_unarmed_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(stage_o));
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));
  a_r6_restart_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active_i |=> cnt == '0);
endmodule

// File: rtl/xpt_route_reg.sv
module xpt_route_reg #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_edge_i,
  input  logic               pending_i,
  input  logic [FRAME_W-1:0] stage_i,
  output logic [FRAME_W-1:0] route_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          route_o <= '0;
    else if (commit_edge_i && pending_i) route_o <= stage_i;
  end

  a_r1_commit_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_edge_i && pending_i) |=> route_o == $past(stage_i));
  a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_edge_i |=> $stable(route_o));
  a_r3_stale_commit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_edge_i && !pending_i) |=> $stable(route_o));
endmodule

// File: rtl/xpt_route_loader.sv
module xpt_route_loader
  import xpt_cfg_pkg::*;
#(
  parameter int NUM_IN  = XPT_INPUTS,
  parameter int NUM_OUT = XPT_OUTPUTS,
  parameter int SYNC    = XPT_SYNC,
  localparam int SEL_W   = $clog2(NUM_IN),
  localparam int WORD_W  = SEL_W + 1,
  localparam int ADDR_W  = $clog2(NUM_OUT),
  localparam int FRAME_W = NUM_OUT * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n_i,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               commit_i,
  input  logic               fmt_addr_i,
  output logic [FRAME_W-1:0] route_o
);
  // Sync bit order: 4 fmt, 3 commit, 2 sel_n, 1 sdata, 0 sclk
  logic [4:0] raw, syn;
  logic       sclk_q, commit_q;
  logic       sclk_rise, sclk_fall, commit_edge;
  logic [FRAME_W-1:0] stage;
  logic       pending;

  assign raw = {fmt_addr_i, commit_i, sel_n_i, sdata_i, sclk_i};

  xpt_in_sync #(.W(5), .STAGES(SYNC), .RST(5'b00100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      sclk_q   <= syn[0];
      commit_q <= syn[3];
    end
  end

  assign sclk_rise   = syn[0] && !sclk_q;
  assign sclk_fall   = !syn[0] && sclk_q;
  assign commit_edge = syn[3] && !commit_q;

  xpt_load #(.OUTS(NUM_OUT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_load (
    .clk(clk), .rst_n(rst_n), .cs_active_i(!syn[2]),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .sdata_i(syn[1]),
    .addr_mode_i(syn[4]), .commit_edge_i(commit_edge),
    .stage_o(stage), .pending_o(pending)
  );

  xpt_route_reg #(.FRAME_W(FRAME_W)) u_route (
    .clk(clk), .rst_n(rst_n), .commit_edge_i(commit_edge),
    .pending_i(pending), .stage_i(stage), .route_o(route_o)
  );

  a_r12_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> route_o == '0);
endmodule

// File: tb/xpt_route_loader_bench.sv
module xpt_route_loader_bench;
  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sclk = 0, sdata = 0, commit = 0, fmt = 0;
  logic [15:0] route;
  logic [15:0] exp_r;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xpt_route_loader u_xpt_route_loader (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk),
    .sdata_i(sdata), .commit_i(commit), .fmt_addr_i(fmt), .route_o(route)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = v[i]; sclk = 1; wait_clk(4);
      sclk = 0; wait_clk(4);
    end
  endtask

  task automatic cs_lo; sel_n = 0; wait_clk(4); endtask
  task automatic cs_hi; sel_n = 1; wait_clk(6); endtask
  task automatic pulse_commit; commit = 1; wait_clk(4); commit = 0; wait_clk(6); endtask

  initial begin
    wait_clk(200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    logic [31:0] v;
    wait_clk(3); rst_n = 1; wait_clk(3);
    chk("R12 reset route", route, 16'h0000);
    exp_r = 16'h0000;
    pulse_commit;
    chk("R12 nothing staged", route, exp_r);

    // Full-frame sweep
    fmt = 0; wait_clk(4);
    for (int i = 0; i < 24; i++) begin
      pat = 16'((i * 16'hA5C3) ^ (i << 5) ^ 16'h1E2D);
      cs_lo; send_bits({16'h0, pat}, 16); cs_hi;
      chk("R2 no commit yet", route, exp_r);
      pulse_commit;
      exp_r = pat;
      chk("R1 R4 full frame", route, exp_r);
    end
    // Field interpretation of the last pattern: output 2 select and enable
    chk("R4 out2 field", {12'h0, route[11:8]}, {12'h0, pat[11:8]});

    // Stale commit and partial frame
    pulse_commit;
    chk("R3 repeat commit", route, exp_r);
    cs_lo; send_bits(32'h15, 5); cs_hi; pulse_commit;
    chk("R3 partial full-frame", route, exp_r);

    // Over-clocking displaces oldest bits
    v = 32'hB_7C39_5;
    cs_lo; send_bits(v, 20); cs_hi; pulse_commit;
    exp_r = v[19:4];
    chk("R8 twenty bits", route, exp_r);

    // Falling edge before any rising edge in session is ignored
    pat = 16'h3C5A;
    sclk = 1; wait_clk(4);
    sel_n = 0; sdata = 1; wait_clk(4);
    sclk = 0; wait_clk(4);
    send_bits({16'h0, pat}, 16); cs_hi; pulse_commit;
    exp_r = pat;
    chk("R7 leading fall ignored", route, exp_r);

    // Deselected clocks capture nothing
    send_bits(32'hFFFF, 16); pulse_commit;
    chk("R9 deselected clocks", route, exp_r);

    // Commit while select is low
    pat = 16'h9817;
    cs_lo; send_bits({16'h0, pat}, 16); pulse_commit;
    exp_r = pat;
    chk("R10 commit with select low", route, exp_r);
    cs_hi;

    // Three-wire: commit tied to select
    pat = 16'h6AE4;
    sel_n = 0; commit = 0; wait_clk(4);
    send_bits({16'h0, pat}, 16);
    sel_n = 1; commit = 1; wait_clk(8);
    exp_r = pat;
    chk("R11 select rise commits", route, exp_r);
    sel_n = 0; commit = 0; wait_clk(4);
    sel_n = 1; commit = 1; wait_clk(8);
    chk("R11 empty frame no change", route, exp_r);
    commit = 0; wait_clk(4);

    // Per-output sweep: every address, every word
    fmt = 1; wait_clk(4);
    for (int a = 0; a < 4; a++) begin
      for (int w = 0; w < 16; w++) begin
        cs_lo; send_bits(32'((w << 2) | a), 6); cs_hi;
        chk("R2 addressed staged only", route, exp_r);
        pulse_commit;
        exp_r[a*4 +: 4] = 4'(w);
        chk("R5 addressed update", route, exp_r);
      end
    end

    // Two frames in one session
    cs_lo; send_bits(32'((((5 << 2) | 1) << 6) | ((12 << 2) | 3)), 12); cs_hi;
    pulse_commit;
    exp_r[12 +: 4] = 4'd12; exp_r[4 +: 4] = 4'd5;
    chk("R5 two frames one session", route, exp_r);

    // Truncated frame
    cs_lo; send_bits(32'hE, 4); cs_hi; pulse_commit;
    chk("R6 truncated frame", route, exp_r);
    cs_lo; send_bits(32'h5, 3); cs_hi;
    cs_lo; send_bits(32'((9 << 2) | 2), 6); cs_hi; pulse_commit;
    exp_r[8 +: 4] = 4'd9;
    chk("R6 restart after truncation", route, exp_r);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule